// File: doc/BRIEF.md
# Handshake Bus Read Requester

This block sits on the device side of a shared, multiplexed address/data bus that has no common clock. A one-cycle local start pulse, together with an address, launches a single word read. The requester puts the address on the shared lines and raises its read request. It lets go of the lines when the memory side acknowledges, and then waits for the memory to mark valid data. It captures the word, answers with its own acknowledge, and finishes once the memory withdraws its data-valid level. Each step is triggered only by a level change from the far side.

Both incoming handshake levels pass through a flop synchronizer before the sequencer uses them. A programmable cycle limit guards every state that waits on the far side. When the limit runs out, the requester returns to idle, releases everything it drives and flags an error.

Top module: `hsr_read_requester`

## Requirements
- R1: While reset is applied, read_req_o, ack_o, bus_oe_o, busy_o, done_o and err_o are low and rdata_o is zero.
- R2: An accepted start latches addr_i. bus_oe_o is high with that address on bus_out_o for at least one cycle before read_req_o rises. The address stays unchanged while bus_oe_o stays high.
- R3: After the synchronized acknowledge is seen high, read_req_o and bus_oe_o fall together in the same cycle.
- R4: ack_o stays low until the synchronized data-valid level has been seen high, after the acknowledge has dropped. rdata_o then holds the bus_in_i word that was present when data-valid was seen.
- R5: ack_o stays high until data-valid is seen low. done_o is a single-cycle pulse in the cycle where ack_o falls.
- R6: A level change on ack_i or data_rdy_i that is applied between two rising edges acts on the outputs after the third rising edge that follows it. This is the effect of two synchronizer flops plus the registered outputs.
- R7: With tmo_limit_i = L > 0, a wait state that lasts L cycles without its awaited level returns the block to idle. err_o then pulses for one cycle without done_o, and read_req_o, ack_o, bus_oe_o and busy_o are low. With no acknowledge at all, read_req_o is high for exactly L cycles.
- R8: If the awaited level is seen in the same cycle as the limit is reached, the handshake advances and no error is flagged.
- R9: tmo_limit_i = 0 disables the timeout, so waits of any length complete normally.
- R10: A start while busy_o is high is ignored. A start presented in the cycle done_o is high is accepted, because the block is idle again.
- R11: busy_o is high from the cycle after an accepted start until the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| start_i | input | 1 | Read launch pulse, sampled while idle |
| addr_i | input | DATA_W | Address to read |
| tmo_limit_i | input | TMO_W | Wait-state cycle limit, 0 disables |
| bus_in_i | input | DATA_W | Shared lines as seen by the requester |
| bus_out_o | output | DATA_W | Value driven onto the shared lines |
| bus_oe_o | output | 1 | Enable of the shared-line drivers |
| read_req_o | output | 1 | Read request level |
| ack_i | input | 1 | Acknowledge level from memory |
| data_rdy_i | input | 1 | Data-valid level from memory |
| ack_o | output | 1 | Acknowledge level to memory |
| rdata_o | output | DATA_W | Captured read word |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle timeout pulse |

## Verification
Two pairs of events can fall in the same cycle: the awaited handshake edge and the expiry of the wait limit, and the completion pulse and a fresh start. For the first pair, the bench sets a limit of 8 and raises the acknowledge on the sixth or on the seventh cycle of the request. Because of the three-edge reaction latency, the sixth lands exactly on the expiry cycle and must advance without error, while the seventh must time out with the request held for exactly 8 cycles. For the second pair, a start is driven in the done cycle and must be taken at once, while starts poked in mid-transfer must leave the block idle after it completes.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

  // Sequencer states of the read requester
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ADDR     = 3'd1,  // address driven, request not yet raised
    ST_REQ      = 3'd2,  // request raised, waiting for acknowledge high
    ST_ACK_LO   = 3'd3,  // lines released, waiting for acknowledge low
    ST_WAIT_RDY = 3'd4,  // waiting for data-valid high
    ST_HOLD_ACK = 3'd5   // own acknowledge raised, waiting for data-valid low
  } hsr_state_e;

  function automatic logic is_wait_state(hsr_state_e s);
    return (s == ST_REQ) || (s == ST_ACK_LO) || (s == ST_WAIT_RDY) || (s == ST_HOLD_ACK);
  endfunction

endpackage

// File: rtl/hsr_rst_sync.sv
module hsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = shift_q[STAGES-1];

endmodule

// File: rtl/hsr_sync.sv
module hsr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hsr_timer.sv
module hsr_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] last_cnt;

  always_comb begin
    cnt_en   = restart_i | run_i;
    cnt_d    = restart_i ? '0 : cnt_q + 1'b1;
    last_cnt = limit_i - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // A limit of zero turns the guard off
  assign expired_o = run_i && (limit_i != '0) && (cnt_q == last_cnt);

endmodule

// File: rtl/hsr_fsm.sv
module hsr_fsm
  import hsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ack_seen_i,
  input  logic rdy_seen_i,
  input  logic expired_i,
  output logic addr_ld_o,
  output logic data_ld_o,
  output logic waiting_o,
  output logic restart_o,
  output logic drive_o,
  output logic req_o,
  output logic ack_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);

  hsr_state_e state_q, state_d;
  logic done_d, err_d;
  logic drive_d, req_d, ack_d, busy_d;
  logic drive_q, req_q, ack_q, busy_q, done_q, err_q;

  // Next-state logic: handshake progress has priority over expiry
  always_comb begin
    state_d   = state_q;
    addr_ld_o = 1'b0;
    data_ld_o = 1'b0;
    done_d    = 1'b0;
    err_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          addr_ld_o = 1'b1;
          state_d   = ST_ADDR;
        end
      end
      ST_ADDR: begin
        state_d = ST_REQ;
      end
      ST_REQ: begin
        if (ack_seen_i) begin
          state_d = ST_ACK_LO;
        end else if (expired_i) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      ST_ACK_LO: begin
        if (!ack_seen_i) begin
          state_d = ST_WAIT_RDY;
        end else if (expired_i) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      ST_WAIT_RDY: begin
        if (rdy_seen_i) begin
          data_ld_o = 1'b1;
          state_d   = ST_HOLD_ACK;
        end else if (expired_i) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      ST_HOLD_ACK: begin
        if (!rdy_seen_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (expired_i) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Output decode from the next state, so every bus-facing level is a flop
  always_comb begin
    drive_d = (state_d == ST_ADDR) || (state_d == ST_REQ);
    req_d   = (state_d == ST_REQ);
    ack_d   = (state_d == ST_HOLD_ACK);
    busy_d  = (state_d != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      drive_q <= 1'b0;
      req_q   <= 1'b0;
      ack_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      drive_q <= drive_d;
      req_q   <= req_d;
      ack_q   <= ack_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign waiting_o = is_wait_state(state_q);
  assign restart_o = (state_d != state_q);
  assign drive_o   = drive_q;
  assign req_o     = req_q;
  assign ack_o     = ack_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign err_o     = err_q;

endmodule

// File: rtl/hsr_read_requester.sv
module hsr_read_requester #(
  parameter int DATA_W      = 32,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic [DATA_W-1:0] bus_in_i,
  output logic [DATA_W-1:0] bus_out_o,
  output logic              bus_oe_o,
  output logic              read_req_o,
  input  logic              ack_i,
  input  logic              data_rdy_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int HS_W = 2;  // acknowledge and data-valid

  logic            rst_n_int;
  logic [HS_W-1:0] hs_raw, hs_seen;
  logic            addr_ld, data_ld, waiting, restart, expired;
  logic [DATA_W-1:0] addr_q, rdata_q;

  hsr_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_int)
  );

  assign hs_raw = {data_rdy_i, ack_i};

  hsr_sync #(.WIDTH(HS_W), .STAGES(SYNC_STAGES)) i_hs_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (hs_raw),
    .q_o   (hs_seen)
  );

  hsr_timer #(.CNT_W(TMO_W)) i_timer (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .run_i     (waiting),
    .restart_i (restart),
    .limit_i   (tmo_limit_i),
    .expired_o (expired)
  );

  hsr_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start_i    (start_i),
    .ack_seen_i (hs_seen[0]),
    .rdy_seen_i (hs_seen[1]),
    .expired_i  (expired),
    .addr_ld_o  (addr_ld),
    .data_ld_o  (data_ld),
    .waiting_o  (waiting),
    .restart_o  (restart),
    .drive_o    (bus_oe_o),
    .req_o      (read_req_o),
    .ack_o      (ack_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  // Address and read-data holding registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      addr_q <= '0;
    end else if (addr_ld) begin
      addr_q <= addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rdata_q <= '0;
    end else if (data_ld) begin
      rdata_q <= bus_in_i;
    end
  end

  assign bus_out_o = addr_q;
  assign rdata_o   = rdata_q;

endmodule

// File: rtl/hsr_read_requester_chk.sv
module hsr_read_requester_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_out_o,
  input logic              bus_oe_o,
  input logic              read_req_o,
  input logic              ack_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o
);

  assert_oe_with_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    read_req_o |-> bus_oe_o);

  assert_addr_before_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_req_o) |-> $past(bus_oe_o));

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe_o && $past(bus_oe_o)) |-> $stable(bus_out_o));

  assert_release_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(read_req_o) |-> !bus_oe_o);

  assert_no_ack_while_driving_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (!bus_oe_o && !read_req_o));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_with_ack_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $fell(ack_o));

  assert_err_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!read_req_o && !ack_o && !bus_oe_o && !busy_o && !done_o));

  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  assert_req_implies_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (read_req_o || ack_o || bus_oe_o) |-> busy_o);

endmodule

bind hsr_read_requester hsr_read_requester_chk #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_out_o  (bus_out_o),
  .bus_oe_o   (bus_oe_o),
  .read_req_o (read_req_o),
  .ack_o      (ack_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/test_hsr_read_requester.sv
`timescale 1ns/1ps
module test_hsr_read_requester;

  localparam int DW = 32;
  localparam int TW = 16;
  localparam logic [DW-1:0] GARB = 32'hDEAD_BEEF;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic          rst_n, start_i, ack_i, data_rdy_i;
  logic [DW-1:0] addr_i, bus_in_i;
  logic [TW-1:0] tmo_limit_i;
  logic [DW-1:0] bus_out_o, rdata_o;
  logic          bus_oe_o, read_req_o, ack_o, busy_o, done_o, err_o;

  int vectors = 0;
  int fails   = 0;
  int mon_checks = 0;
  int mon_fails  = 0;
  logic prev_done = 1'b0;

  hsr_read_requester #(.DATA_W(DW), .TMO_W(TW)) i_hsr_read_requester (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .tmo_limit_i(tmo_limit_i), .bus_in_i(bus_in_i), .bus_out_o(bus_out_o),
    .bus_oe_o(bus_oe_o), .read_req_o(read_req_o), .ack_i(ack_i),
    .data_rdy_i(data_rdy_i), .ack_o(ack_o), .rdata_o(rdata_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  // Memory contents model
  function automatic logic [DW-1:0] mem_word(input logic [DW-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // R5: done must never be high on two samples in a row
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      mon_checks++;
      if (prev_done) begin
        mon_fails++;
        $display("FAIL R5 done width: actual 2+ cycles expected 1");
      end
    end
    prev_done = done_o;
  end

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_err(input int limit, output int n);
    n = 0;
    while (!err_o && n < limit + 20) begin
      @(negedge clk);
      n++;
    end
  endtask

  // One read; fault 0 none, 1 no ack, 2 ack stuck, 3 no data-valid, 4 data-valid stuck
  task automatic run_txn(input logic [DW-1:0] a, input int limit, input int fault,
                         input int d1, input int d2, input int d3, input int d4,
                         input bit poke, input bit skip_start);
    int k;
    bit exp_to, ok, prev_oe;
    logic [DW-1:0] exp_d;
    string t;
    exp_d  = mem_word(a);
    exp_to = (limit != 0) && ((fault == 1) || (d1 + 2 > limit));
    if (!skip_start) begin
      tmo_limit_i = limit[TW-1:0];
      addr_i  = a;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      addr_i  = ~a;
      chk(busy_o == 1'b1, "R11", "busy after start", busy_o, 1);
    end
    prev_oe = bus_oe_o;
    k = 0;
    while (!read_req_o && k < 10) begin
      prev_oe = bus_oe_o;
      @(negedge clk);
      k++;
    end
    chk(read_req_o == 1'b1, "R2", "request raised", read_req_o, 1);
    chk(prev_oe, "R2", "address driven before request", prev_oe, 1);
    chk(bus_out_o == a, "R2", "address on lines", bus_out_o, a);
    // request phase
    k = 0;
    while (read_req_o && k < 5000) begin
      k++;
      if (fault != 1 && k == d1) ack_i = 1'b1;
      @(negedge clk);
    end
    if (exp_to) begin
      chk(err_o == 1'b1, "R7", "timeout in request", err_o, 1);
      chk(k == limit, "R7", "request cycles before timeout", k, limit);
      chk(!bus_oe_o && !ack_o && !busy_o && !done_o, "R7", "lines released",
          {bus_oe_o, ack_o, busy_o, done_o}, 0);
      ack_i = 1'b0;
      settle();
      return;
    end
    t = (limit != 0 && d1 + 2 == limit) ? "R8" : "R3";
    chk(err_o == 1'b0, t, "no error on acknowledge", err_o, 0);
    chk(k == d1 + 2, "R6", "request cycles after acknowledge", k, d1 + 2);
    chk(bus_oe_o == 1'b0, "R3", "lines released with request", bus_oe_o, 0);
    chk(busy_o == 1'b1, "R11", "busy mid transfer", busy_o, 1);
    if (fault == 2) begin
      wait_err(limit, k);
      chk(err_o == 1'b1, "R7", "timeout waiting acknowledge low", err_o, 1);
      chk(!ack_o && !busy_o && !done_o, "R7", "idle after timeout", {ack_o, busy_o, done_o}, 0);
      ack_i = 1'b0;
      settle();
      return;
    end
    repeat (d2) @(negedge clk);
    ack_i = 1'b0;
    ok = 1'b1;
    if (fault == 3) begin
      k = 0;
      while (!err_o && k < limit + 20) begin
        if (ack_o) ok = 1'b0;
        @(negedge clk);
        k++;
      end
      chk(err_o == 1'b1, "R7", "timeout waiting data-valid", err_o, 1);
      chk(ok, "R4", "no acknowledge without data-valid", ok, 1);
      settle();
      return;
    end
    for (int i = 0; i < d3 + 3; i++) begin
      if (ack_o) ok = 1'b0;
      if (poke && i == 1) begin addr_i = ~a; start_i = 1'b1; end
      if (poke && i == 2) start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(ok, "R4", "no acknowledge before data-valid", ok, 1);
    bus_in_i   = exp_d;
    data_rdy_i = 1'b1;
    k = 0;
    while (!ack_o && k < 10) begin
      @(negedge clk);
      k++;
    end
    chk(ack_o == 1'b1, "R5", "acknowledge raised", ack_o, 1);
    chk(k == 3, "R6", "acknowledge latency", k, 3);
    chk(rdata_o == exp_d, "R4", "captured word", rdata_o, exp_d);
    if (fault == 4) begin
      wait_err(limit, k);
      chk(err_o == 1'b1, "R7", "timeout waiting data-valid low", err_o, 1);
      chk(!ack_o && !done_o, "R7", "acknowledge dropped on timeout", {ack_o, done_o}, 0);
      data_rdy_i = 1'b0;
      bus_in_i   = GARB;
      settle();
      return;
    end
    ok = 1'b1;
    repeat (d4) begin
      @(negedge clk);
      if (!ack_o) ok = 1'b0;
    end
    chk(ok, "R5", "acknowledge held while data-valid", ok, 1);
    data_rdy_i = 1'b0;
    bus_in_i   = GARB;
    k = 0;
    while (!done_o && k < 10) begin
      @(negedge clk);
      k++;
    end
    chk(done_o == 1'b1, "R5", "done pulse", done_o, 1);
    chk(k == 3, "R6", "done latency", k, 3);
    chk(ack_o == 1'b0 && err_o == 1'b0, "R5", "acknowledge falls with done", {ack_o, err_o}, 0);
    chk(rdata_o == exp_d, "R4", "read word after done", rdata_o, exp_d);
    if (poke) begin
      ok = 1'b1;
      repeat (3) begin
        @(negedge clk);
        if (busy_o || bus_oe_o || read_req_o) ok = 1'b0;
      end
      chk(ok, "R10", "start while busy ignored", ok, 1);
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL R5 watchdog: actual still running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors + mon_checks + 1, fails + mon_fails);
    $finish;
  end

  initial begin
    int unused_seed;
    rst_n = 1'b0; start_i = 1'b0; addr_i = '0; bus_in_i = GARB;
    tmo_limit_i = '0; ack_i = 1'b0; data_rdy_i = 1'b0;
    unused_seed = $urandom(32'h00C0_FFEE);
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(!read_req_o && !ack_o && !bus_oe_o, "R1", "handshake outputs in reset",
        {read_req_o, ack_o, bus_oe_o}, 0);
    chk(!busy_o && !done_o && !err_o, "R1", "status outputs in reset", {busy_o, done_o, err_o}, 0);
    chk(rdata_o == '0, "R1", "read data in reset", rdata_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // directed corners
    run_txn(32'h0000_1000, 0, 0, 1, 0, 0, 0, 1'b0, 1'b0);
    run_txn(32'h1234_0004, 8, 0, 6, 2, 2, 2, 1'b0, 1'b0);  // R8 same-cycle race
    run_txn(32'h1234_0008, 8, 0, 7, 2, 2, 2, 1'b0, 1'b0);  // R7 one cycle late
    run_txn(32'h0000_00F0, 5, 1, 0, 0, 0, 0, 1'b0, 1'b0);  // R7 no acknowledge
    run_txn(32'h0000_00F4, 10, 2, 2, 0, 0, 0, 1'b0, 1'b0);
    run_txn(32'h0000_00F8, 10, 3, 2, 1, 0, 0, 1'b0, 1'b0);
    run_txn(32'h0000_00FC, 10, 4, 2, 1, 1, 0, 1'b0, 1'b0);
    run_txn(32'hCAFE_0000, 0, 0, 70, 30, 40, 30, 1'b1, 1'b0);  // R9 long waits, R10 poke
    // R10: start in the done cycle is accepted
    run_txn(32'h0BAD_0010, 0, 0, 3, 1, 1, 1, 1'b0, 1'b0);
    addr_i = 32'h0BAD_0020; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R10", "start in done cycle accepted", busy_o, 1);
    run_txn(32'h0BAD_0020, 0, 0, 2, 1, 1, 1, 1'b0, 1'b1);

    // constrained random
    for (int n = 0; n < 200; n++) begin
      logic [DW-1:0] a;
      int r, fault, limit;
      a = $urandom;
      r = int'($urandom % 10);
      fault = (r < 6) ? 0 : r - 5;
      if (fault == 0) limit = ($urandom % 2 == 0) ? 0 : 40 + int'($urandom % 20);
      else limit = 12 + int'($urandom % 10);
      run_txn(a, limit, fault, 1 + int'($urandom % 6), int'($urandom % 6),
              int'($urandom % 6), int'($urandom % 6),
              (fault == 0) && ($urandom % 3 == 0), 1'b0);
    end
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors + mon_checks, fails + mon_fails);
    $finish;
  end

endmodule